// File: doc/BRIEF.md
# HyperBus Line-Segment Read Controller

This block is the memory-side engine of a video line buffer refill. On a request it opens one read burst on a HyperBus-style DDR memory and fetches a fixed 480-byte line segment. It places the segment into one of three sections of a local line buffer, picked by a section index that comes with the request. The block drives the chip select and the memory clock. It drives the 8-bit data bus while it sends the six command-address bytes, counts latency as clock transitions, and then takes one data byte on every clock transition. Each byte goes out through a single-cycle write port into the buffer.

The memory clock runs at one quarter of the system clock. Each half period lasts two system cycles, and the data driven by the block changes one cycle away from every clock edge. Latency counting overlaps the command-address phase, so the block needs fewer transitions than a plain latency count would suggest. The extra latency period is added only when the memory raises RWDS during the command-address phase. After the last byte the block pulses `done`, keeps chip select high for a guard interval, and then accepts the next request.

Top module: `hyper_line_fetch`

## Requirements
- R1: While reset is held and directly after it, `csN` is 1, `ck` is 0, `busy` is 0, `done` is 0 and `bufWe` is 0.
- R2: A burst begins with six command-address bytes on `dq`, one per `ck` transition. The first byte goes out on a rising edge and the edges then alternate. The 48-bit word is sent most significant byte first: bit 47 = 1 (read), bit 46 = 0 (memory space), bit 45 = 1 (linear burst), and bits 44:0 hold `memAddr` zero-extended.
- R3: With latency parameter L (4, 5 or 6), the first data byte follows 6 + 2*(L-1) transitions of `ck` after `csN` falls. If `rwds` is 1 when the command-address phase ends, a further 2*L transitions are inserted. For the default L = 5 this gives 8 or 18 latency transitions.
- R4: While `csN` is low, `ck` toggles exactly every two system cycles (one quarter of the system clock rate). While `csN` is high, `ck` is 0.
- R5: Each burst writes exactly 480 bytes through `bufWe` to buffer addresses section*480 through section*480+479, in ascending order. Byte j is the value the memory drives after data-phase transition j. Buffer addresses outside that section are not written.
- R6: A request with `section` equal to 3 or higher is ignored: `busy` stays 0, `csN` stays 1 and nothing is written.
- R7: A `start` raised while `busy` is 1 is ignored. The running burst completes unchanged and no second burst follows.
- R8: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse in the cycle after the last buffer write.
- R9: Between two bursts, `csN` stays high for at least four system cycles (one memory clock), even if `start` is held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a segment fetch |
| section | input | 2 | Target buffer section, 0 to 2 |
| memAddr | input | 32 | Memory address placed in the command word |
| busy | output | 1 | A burst or its guard interval is in progress |
| done | output | 1 | One-cycle pulse after the last buffer write |
| csN | output | 1 | Memory chip select, active low |
| ck | output | 1 | Memory clock |
| dq | inout | 8 | Memory data bus; driven by the block only during the command-address phase |
| rwds | input | 1 | Memory read/write data strobe; needs a pull-down outside the block |
| bufWe | output | 1 | Line buffer write enable |
| bufAddr | output | 11 | Line buffer byte address |
| bufData | output | 8 | Line buffer write data |

## Verification
The hardest case to reach is the doubled-latency path. It depends on the memory raising `rwds` during the command-address phase and then releasing it, and the block sees this only at one edge. The bench's memory model drives `rwds` high or low per burst, chosen by direction or at random, and releases it after the sixth transition. A wrong transition count then shows up as a shifted byte pattern in the buffer section. The guard interval is reached by holding `start` high from the cycle `done` appears, so the block's own wait is the only thing that keeps `csN` high.

// File: rtl/hlf_pkg.sv
package hlf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_LAT,
    ST_DATA,
    ST_TAIL,
    ST_FIN,
    ST_GAP
  } hlfState_t;

  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadCa;     // latch command word, section base, enable bus drive
    logic shiftCa;    // advance to the next command byte
    logic ckToggle;   // flip the memory clock at the next edge
    logic releaseDq;  // stop driving the data bus
    logic capture;    // sample the bus into the line buffer port
  } hlfStrobe_t;

  localparam int CA_BYTES = 6;

endpackage

// File: rtl/hlf_ctrl.sv
module hlf_ctrl
  import hlf_pkg::*;
#(
  parameter int LATENCY    = 5,
  parameter int SEC_BYTES  = 480,
  parameter int NUM_SEC    = 3,
  parameter int SEC_W      = 2,
  parameter int GAP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SEC_W-1:0] section,
  input  logic             rwds,
  output hlfStrobe_t       strobe,
  output logic             csN,
  output logic             busy,
  output logic             done
);

  localparam int LAT_FIRST  = 2 * (LATENCY - 1);
  localparam int LAT_SECOND = 2 * LATENCY;
  localparam int LAT_MAX    = LAT_FIRST + LAT_SECOND;
  localparam int CNT_TOP    = (SEC_BYTES > LAT_MAX) ? SEC_BYTES : LAT_MAX;
  localparam int CNT_W      = $clog2(CNT_TOP) + 1;
  localparam int GAP_W      = $clog2(GAP_CYCLES) + 1;

  hlfState_t        state;
  logic             ph;        // 0: first cycle of a slot, 1: second cycle
  logic [CNT_W-1:0] slotCnt;
  logic [CNT_W-1:0] latLast;
  logic [GAP_W-1:0] gapCnt;
  logic             accept;

  assign accept = (state == ST_IDLE) && start &&
                  ({1'b0, section} < (SEC_W + 1)'(NUM_SEC));

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.loadCa = accept;
      ST_CMD: begin
        strobe.ckToggle = ph;
        strobe.shiftCa  = !ph && (slotCnt != '0);
      end
      ST_LAT: begin
        strobe.ckToggle  = ph;
        strobe.releaseDq = !ph && (slotCnt == '0);
      end
      ST_DATA: begin
        strobe.ckToggle = ph;
        strobe.capture  = !ph && (slotCnt != '0);
      end
      ST_TAIL: strobe.capture = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ph      <= 1'b0;
      slotCnt <= '0;
      latLast <= '0;
      gapCnt  <= '0;
      csN     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_CMD;
            ph      <= 1'b0;
            slotCnt <= '0;
            csN     <= 1'b0;
          end
        end
        ST_CMD: begin
          ph <= ~ph;
          if (ph) begin
            if (slotCnt == CNT_W'(CA_BYTES - 1)) begin
              state   <= ST_LAT;
              slotCnt <= '0;
              latLast <= rwds ? CNT_W'(LAT_MAX - 1) : CNT_W'(LAT_FIRST - 1);
            end else begin
              slotCnt <= slotCnt + CNT_W'(1);
            end
          end
        end
        ST_LAT: begin
          ph <= ~ph;
          if (ph) begin
            if (slotCnt == latLast) begin
              state   <= ST_DATA;
              slotCnt <= '0;
            end else begin
              slotCnt <= slotCnt + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          ph <= ~ph;
          if (ph) begin
            if (slotCnt == CNT_W'(SEC_BYTES - 1)) begin
              state <= ST_TAIL;
            end else begin
              slotCnt <= slotCnt + CNT_W'(1);
            end
          end
        end
        ST_TAIL: begin
          state <= ST_FIN;
          csN   <= 1'b1;
        end
        ST_FIN: begin
          state  <= ST_GAP;
          gapCnt <= '0;
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(GAP_CYCLES - 1)) state <= ST_IDLE;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_GAP) && (gapCnt == '0);

endmodule

// File: rtl/hlf_dpath.sv
module hlf_dpath
  import hlf_pkg::*;
#(
  parameter int SEC_BYTES = 480,
  parameter int SEC_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int BUF_AW    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  hlfStrobe_t        strobe,
  input  logic [SEC_W-1:0]  section,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        dqIn,
  output logic              ck,
  output logic [7:0]        dqOut,
  output logic              dqOe,
  output logic              bufWe,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [7:0]        bufData
);

  localparam int CA_W       = CA_BYTES * 8;
  localparam int ADDR_FIELD = CA_W - 3;

  logic [CA_W-1:0]   caShift;
  logic [CA_W-1:0]   caWord;
  logic [BUF_AW-1:0] secBase;
  logic [BUF_AW-1:0] wrIdx;

  // read, memory space, linear burst, then the address field
  assign caWord = {1'b1, 1'b0, 1'b1, ADDR_FIELD'(memAddr)};
  assign dqOut  = caShift[CA_W-1 -: 8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      caShift <= '0;
      secBase <= '0;
      wrIdx   <= '0;
      dqOe    <= 1'b0;
      ck      <= 1'b0;
      bufWe   <= 1'b0;
      bufAddr <= '0;
      bufData <= '0;
    end else begin
      if (strobe.loadCa) begin
        caShift <= caWord;
        secBase <= BUF_AW'(section) * BUF_AW'(SEC_BYTES);
        wrIdx   <= '0;
        dqOe    <= 1'b1;
      end else if (strobe.shiftCa) begin
        caShift <= {caShift[CA_W-9:0], 8'h00};
      end
      if (strobe.releaseDq) dqOe <= 1'b0;
      if (strobe.ckToggle) ck <= ~ck;
      bufWe <= strobe.capture;
      if (strobe.capture) begin
        bufData <= dqIn;
        bufAddr <= secBase + wrIdx;
        wrIdx   <= wrIdx + BUF_AW'(1);
      end
    end
  end

endmodule

// File: rtl/hyper_line_fetch.sv
module hyper_line_fetch
  import hlf_pkg::*;
#(
  parameter int LATENCY   = 5,
  parameter int SEC_BYTES = 480,
  parameter int NUM_SEC   = 3,
  parameter int ADDR_W    = 32,
  localparam int SEC_W     = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
  localparam int BUF_DEPTH = SEC_BYTES * NUM_SEC,
  localparam int BUF_AW    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SEC_W-1:0]  section,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              done,
  output logic              csN,
  output logic              ck,
  inout  wire  [7:0]        dq,
  input  logic              rwds,
  output logic              bufWe,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [7:0]        bufData
);

  hlfStrobe_t strobe;
  logic [7:0] dqOut;
  logic       dqOe;

  assign dq = dqOe ? dqOut : 8'hzz;

  hlf_ctrl #(
    .LATENCY(LATENCY), .SEC_BYTES(SEC_BYTES), .NUM_SEC(NUM_SEC),
    .SEC_W(SEC_W), .GAP_CYCLES(4)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .section(section), .rwds(rwds),
    .strobe(strobe), .csN(csN), .busy(busy), .done(done)
  );

  hlf_dpath #(
    .SEC_BYTES(SEC_BYTES), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .BUF_AW(BUF_AW)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .section(section),
    .memAddr(memAddr), .dqIn(dq), .ck(ck), .dqOut(dqOut), .dqOe(dqOe),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

endmodule

// File: rtl/hyper_line_fetch_chk.sv
module hyper_line_fetch_chk #(
  parameter int NUM_SEC = 3,
  parameter int SEC_W   = 2,
  parameter int DEPTH   = 1440,
  parameter int AW      = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [SEC_W-1:0] section,
  input logic             busy,
  input logic             done,
  input logic             csN,
  input logic             ck,
  input logic             bufWe,
  input logic [AW-1:0]    bufAddr
);

  logic [3:0] hiCnt;
  logic       seenLow;
  logic       validSec;

  assign validSec = {1'b0, section} < (SEC_W + 1)'(NUM_SEC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt   <= '0;
      seenLow <= 1'b0;
    end else begin
      if (csN) hiCnt <= (hiCnt == 4'hf) ? hiCnt : hiCnt + 4'd1;
      else hiCnt <= '0;
      if (!csN) seenLow <= 1'b1;
    end
  end

  assert_ck_quarter_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ck != $past(ck)) |=> (ck == $past(ck)));

  assert_ck_rest_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !ck);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(bufWe));

  assert_busy_on_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && validSec) |=> busy);

  assert_write_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (32'(bufAddr) < DEPTH));

  assert_bad_section_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !validSec) |=> !busy);

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && seenLow) |-> (hiCnt >= 4'd4));

endmodule

bind hyper_line_fetch hyper_line_fetch_chk #(
  .NUM_SEC(NUM_SEC), .SEC_W(SEC_W), .DEPTH(BUF_DEPTH), .AW(BUF_AW)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .section(section), .busy(busy),
  .done(done), .csN(csN), .ck(ck), .bufWe(bufWe), .bufAddr(bufAddr)
);

// File: tb/hyper_line_fetch_tb_top.sv
module hyper_line_fetch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;
  localparam int SEC_BYTES  = 480;
  localparam int NSEC       = 3;
  localparam int DEPTH      = SEC_BYTES * NSEC;
  localparam int AW         = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    section = '0;
  logic [31:0]   memAddr = '0;
  wire           busy, done, csN, ck, bufWe;
  wire  [AW-1:0] bufAddr;
  wire  [7:0]    bufData;
  wire  [7:0]    dq;
  logic          memOe = 1'b0;
  logic [7:0]    memDq = '0;
  logic          rwdsOe = 1'b0;
  logic          rwdsVal = 1'b0;
  wire           rwds;

  assign dq   = memOe ? memDq : 8'hzz;
  assign rwds = rwdsOe ? rwdsVal : 1'b0;  // released line reads low

  always #(CLK_PERIOD / 2) clk = ~clk;

  hyper_line_fetch #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .section(section), .memAddr(memAddr),
    .busy(busy), .done(done), .csN(csN), .ck(ck), .dq(dq), .rwds(rwds),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a, input int j);
    return 8'(a[7:0] * 3) ^ 8'(j * 29) ^ 8'(j >> 4);
  endfunction

  function automatic logic [7:0] caByte(input logic [31:0] a, input int k);
    logic [47:0] w;
    w = {3'b101, 45'(a)};
    return w[47 - 8 * k -: 8];
  endfunction

  // memory model
  logic [7:0]  caSeen [6];
  logic [31:0] curAddr = '0;
  bit          dblMode = 0;
  int          transDone = 0;

  initial begin
    forever begin
      int memTrans;
      int memN;
      @(negedge csN);
      memTrans = 0;
      memN = 2 * (LAT - 1) + (dblMode ? 2 * LAT : 0);
      rwdsVal = dblMode;
      rwdsOe = 1'b1;
      forever begin
        @(ck or posedge csN);
        if (csN) break;
        if (memTrans < 6) caSeen[memTrans] = dq;
        if (memTrans == 6) rwdsOe = 1'b0;
        if (memTrans >= 6 + memN && memTrans < 6 + memN + SEC_BYTES) begin
          #1;
          memDq = pat(curAddr, memTrans - 6 - memN);
          memOe = 1'b1;
        end
        memTrans++;
      end
      memOe = 1'b0;
      rwdsOe = 1'b0;
      transDone = memTrans;
    end
  end

  // port monitor
  logic [7:0] obsBuf [DEPTH];
  logic [7:0] expBuf [DEPTH];
  int wrCount = 0, firstAddr = 0, lastAddr = 0, doneCount = 0, hiRun = 0, sinceTog = 0;
  bit orderBad = 0, doneBad = 0, rateBad = 0, ckRestBad = 0, gapBad = 0;
  bit prevWe = 0, prevCk = 0, prevCsN = 1, seenTog = 0, seenLowEver = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (bufWe) begin
        obsBuf[bufAddr] = bufData;
        wrCount++;
        if (wrCount == 1) firstAddr = int'(bufAddr);
        else if (int'(bufAddr) != lastAddr + 1) orderBad = 1;
        lastAddr = int'(bufAddr);
      end
      if (done) begin
        doneCount++;
        if (!prevWe) doneBad = 1;
      end
      if (!csN) begin
        if (ck != prevCk) begin
          if (seenTog && sinceTog != 2) rateBad = 1;
          seenTog = 1;
          sinceTog = 1;
        end else begin
          sinceTog++;
        end
        if (prevCsN && seenLowEver && hiRun < 4) gapBad = 1;
        hiRun = 0;
        seenLowEver = 1;
      end else begin
        seenTog = 0;
        sinceTog = 0;
        if (ck) ckRestBad = 1;
        hiRun++;
      end
      prevWe = bufWe;
      prevCk = ck;
      prevCsN = csN;
    end
  end

  task automatic runBurst(input int sec, input logic [31:0] addr, input bit dbl,
                          input bit poke);
    int mism;
    int expTrans;
    wrCount = 0; orderBad = 0; doneCount = 0; doneBad = 0; rateBad = 0; ckRestBad = 0;
    dblMode = dbl;
    curAddr = addr;
    @(posedge clk); #1;
    start = 1'b1;
    section = 2'(sec);
    memAddr = addr;
    do begin
      @(posedge clk); #1;
    end while (csN);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    if (poke) begin
      repeat (100) @(posedge clk);
      #1;
      start = 1'b1;
      section = 2'((sec + 1) % NSEC);
      memAddr = ~addr;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (!done) begin
      @(posedge clk); #1;
    end
    @(negedge clk); #1;
    for (int j = 0; j < SEC_BYTES; j++) expBuf[sec * SEC_BYTES + j] = pat(addr, j);
    for (int k = 0; k < 6; k++)
      check(caSeen[k] === caByte(addr, k), "R2", $sformatf("command byte %0d", k),
            caSeen[k], caByte(addr, k));
    expTrans = 6 + 2 * (LAT - 1) + (dbl ? 2 * LAT : 0) + SEC_BYTES;
    check(transDone == expTrans, "R3", "clock transitions in burst", transDone, expTrans);
    check(wrCount == SEC_BYTES && !orderBad, "R5", "write count/order", wrCount, SEC_BYTES);
    check(firstAddr == sec * SEC_BYTES && lastAddr == sec * SEC_BYTES + SEC_BYTES - 1,
          "R5", "section address range", firstAddr, sec * SEC_BYTES);
    mism = 0;
    for (int i = 0; i < DEPTH; i++) if (obsBuf[i] !== expBuf[i]) mism++;
    check(mism == 0, "R5", "buffer mismatches (R3 latency shifts data)", mism, 0);
    check(doneCount == 1 && !doneBad, "R8", "done pulses after last write", doneCount, 1);
    check(!rateBad && !ckRestBad, "R4", "clock rate and rest level", {rateBad, ckRestBad}, 0);
    if (poke) begin
      repeat (10) @(posedge clk);
      #1;
      check(busy == 1'b0 && csN == 1'b1 && wrCount == SEC_BYTES, "R7",
            "start during burst ignored", wrCount, SEC_BYTES);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) begin
      obsBuf[i] = 8'h00;
      expBuf[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    #1;
    check(csN == 1'b1 && ck == 1'b0, "R1", "bus idle in reset", {csN, ck}, 2'b10);
    check(busy == 1'b0 && done == 1'b0 && bufWe == 1'b0, "R1", "flags in reset",
          {busy, done, bufWe}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(csN == 1'b1 && ck == 1'b0 && busy == 1'b0, "R1", "state after reset",
          {csN, ck, busy}, 3'b100);

    runBurst(0, 32'h0001_2345, 1'b0, 1'b0);
    runBurst(2, 32'hFFFF_FFFF, 1'b1, 1'b0);
    runBurst(1, 32'h0000_0000, 1'b0, 1'b1);

    // R6: invalid section
    wrCount = 0;
    @(posedge clk); #1;
    start = 1'b1; section = 2'd3; memAddr = 32'h55;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0 && csN == 1'b1 && wrCount == 0, "R6", "section 3 ignored",
          {busy, csN}, 2'b01);

    // R9: back to back, start raised as soon as done is seen
    runBurst(1, 32'h00AB_CDEF, 1'b1, 1'b0);
    runBurst(0, 32'h1234_5678, 1'b0, 1'b0);

    for (int n = 0; n < 6; n++)
      runBurst(int'($urandom_range(0, NSEC - 1)), $urandom(), bit'($urandom_range(0, 1)), 1'b0);

    check(!gapBad, "R9", "chip select guard interval", gapBad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule